// File: doc/BRIEF.md
# Multi-source clock timing generator

This block derives every timing strobe a small microcontroller needs from two free-running reference ticks: a fast one (`hf_tick`) and a slow one (`lf_tick`). Both arrive as single-cycle enables in one synchronous clock domain. A two-bit prescaler and the first six divider stages always count fast ticks. The upper fifteen stages (7 to 21) count either the carry out of stage 6 or the slow tick. The block also produces the system-clock enable, which comes from one of the two reference ticks, and a machine-cycle strobe that fires on every fourth system tick.

Every stage is reported as a one-cycle pulse on `tap_en`, with bit n-1 standing for stage n. Five named taps for downstream consumers are picked out of that vector by parameters: time base, watchdog, timer/counters, divider output and warm-up. Applying a new clock selection waits for a cycle in which neither candidate source is ticking, so no stage ever misses a count or counts twice. The whole chain is held at zero while `stop_mode` is high and for one further cycle after it falls.

Top module: `tgen_top`

## Requirements
- R1: While `rst_n` is low, `sys_en`, `mcyc_stb`, `tap_en`, all five named taps and `div_state` are all zero.
- R2: `sys_en` is high in the cycle after `hf_tick` is high when the applied system source is fast, and in the cycle after `lf_tick` is high when the applied system source is slow.
- R3: The applied system source takes the value of `sys_slow` (1 = slow) only at a clock edge where both `hf_tick` and `lf_tick` are low. Otherwise it keeps its previous value. Reset applies fast.
- R4: `mcyc_stb` is high in the cycle after every fourth system tick counted since reset or since the last clear. It is never high in two consecutive cycles.
- R5: For stages n = 1..6, `tap_en[n-1]` pulses in the cycle after the fast tick whose count, taken since the last clear, is a multiple of 2^(n+2).
- R6: The stage-7 source is the stage-6 pulse when the applied stage-7 select is 0, and `lf_tick` when it is 1. For stages m = 7..21, `tap_en[m-1]` pulses in the cycle after the source tick whose count is a multiple of 2^(m-6).
- R7: The applied stage-7 select takes `sys_slow | s7_from_lf` only at an edge where `lf_tick` and the stage-6 pulse are both low. Reset applies 0.
- R8: While `stop_mode` is high, and in the cycle after it falls, the counters are cleared. `div_state`, `tap_en`, `sys_en` and `mcyc_stb` then read zero one cycle later.
- R9: `tbt_tick`, `wdt_tick`, `tmr_tick`, `dvo_tick` and `wup_tick` equal `tap_en` bits 13, 20, 2, 9 and 7 (stages 14, 21, 3, 10, 8) by default.
- R10: `div_state` is {upper count (15 bits), lower count (8 bits)}. The lower half counts fast ticks modulo 256, and the upper half counts stage-7 source ticks modulo 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single synchronous clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_tick | input | 1 | Fast reference tick enable |
| lf_tick | input | 1 | Slow reference tick enable |
| stop_mode | input | 1 | High while the oscillators are halted |
| sys_slow | input | 1 | Requested system source, 1 = slow |
| s7_from_lf | input | 1 | Requested stage-7 source in fast mode, 1 = slow tick |
| sys_en | output | 1 | System clock enable |
| mcyc_stb | output | 1 | Machine-cycle strobe |
| tap_en | output | 21 | Stage pulses, bit n-1 = stage n |
| tbt_tick | output | 1 | Time-base source tap |
| wdt_tick | output | 1 | Watchdog source tap |
| tmr_tick | output | 1 | Timer/counter source tap |
| dvo_tick | output | 1 | Divider-output source tap |
| wup_tick | output | 1 | Warm-up source tap |
| div_state | output | 23 | Chain count, {upper, lower} |

## Verification
The hardest state to reach is the top of the chain. Stage 21 only fires after 2^15 stage-7 source ticks, and the fast path would need 2^23 fast ticks to get there. The stimulus therefore routes the slow tick into stage 7 and ticks it every third cycle, so stage 21 wraps once in a run of about a hundred thousand cycles. Select changes that collide with a tick on either candidate source are provoked by toggling both select inputs on awkward cycle counts while the fast and slow ticks run with co-prime periods. The behavioural model compares every output on every cycle.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
    localparam int TG_PRE_W  = 2;
    localparam int TG_STAGES = 21;
    localparam int TG_SPLIT  = 6;
    localparam int TG_MC_DIV = 4;

    typedef enum logic {
        SRC_FAST = 1'b0,
        SRC_SLOW = 1'b1
    } src_sel_e;
endpackage

// File: rtl/tgen_fast_chain.sv
// Prescaler plus the lower divider stages, always clocked by the fast tick.
module tgen_fast_chain #(
    parameter int PRE_W = 2,
    parameter int SPLIT = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   tick,
    output logic [PRE_W+SPLIT-1:0] cnt,
    output logic [SPLIT-1:0]       stage_tick
);
    localparam int W = PRE_W + SPLIT;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr) cnt_d = '0;
        else     cnt_d = cnt_q + W'(tick);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // stage g+1 carries out when all bits up to and including it are set
    for (genvar g = 0; g < SPLIT; g++) begin : g_stage
        assign stage_tick[g] = tick & (&cnt_q[PRE_W+g:0]);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tgen_slow_chain.sv
// Upper divider stages, clocked by the selected stage-7 source.
module tgen_slow_chain #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic [W-1:0] stage_tick
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr) cnt_d = '0;
        else     cnt_d = cnt_q + W'(tick);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_stage
        assign stage_tick[g] = tick & (&cnt_q[g:0]);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tgen_mcycle.sv
// Machine-cycle counter: one strobe per MC_DIV system ticks.
module tgen_mcycle #(
    parameter int MC_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic stb
);
    localparam int CW = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(MC_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stb = tick & (cnt_q == LAST);
endmodule

// File: rtl/tgen_top.sv
module tgen_top
    import tgen_pkg::*;
#(
    parameter int PRE_W     = TG_PRE_W,
    parameter int N_STAGES  = TG_STAGES,
    parameter int SPLIT     = TG_SPLIT,
    parameter int MC_DIV    = TG_MC_DIV,
    parameter int TBT_STAGE = 14,
    parameter int WDT_STAGE = 21,
    parameter int TMR_STAGE = 3,
    parameter int DVO_STAGE = 10,
    parameter int WUP_STAGE = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hf_tick,
    input  logic                         lf_tick,
    input  logic                         stop_mode,
    input  logic                         sys_slow,
    input  logic                         s7_from_lf,
    output logic                         sys_en,
    output logic                         mcyc_stb,
    output logic [N_STAGES-1:0]          tap_en,
    output logic                         tbt_tick,
    output logic                         wdt_tick,
    output logic                         tmr_tick,
    output logic                         dvo_tick,
    output logic                         wup_tick,
    output logic [N_STAGES+PRE_W-1:0]    div_state
);
    localparam int LO_W = PRE_W + SPLIT;
    localparam int HI_W = N_STAGES - SPLIT;

    typedef struct packed {
        logic                stop;
        src_sel_e            sel_sys;
        src_sel_e            sel7;
        logic                sys_en;
        logic                mcyc;
        logic [N_STAGES-1:0] taps;
    } st_t;

    st_t st_d, st_q;

    logic            clr;
    logic            sys_tick;
    logic            src7;
    logic            mc_stb;
    logic [LO_W-1:0] lo_cnt;
    logic [HI_W-1:0] hi_cnt;
    logic [SPLIT-1:0] lo_stage;
    logic [HI_W-1:0]  hi_stage;

    // clear on STOP entry, during STOP and on the cycle of exit
    assign clr      = stop_mode | st_q.stop;
    assign sys_tick = (st_q.sel_sys == SRC_SLOW) ? lf_tick : hf_tick;
    assign src7     = (st_q.sel7 == SRC_SLOW) ? lf_tick : lo_stage[SPLIT-1];

    tgen_fast_chain #(.PRE_W(PRE_W), .SPLIT(SPLIT)) u_fast (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .tick       (hf_tick),
        .cnt        (lo_cnt),
        .stage_tick (lo_stage)
    );

    tgen_slow_chain #(.W(HI_W)) u_slow (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .tick       (src7),
        .cnt        (hi_cnt),
        .stage_tick (hi_stage)
    );

    tgen_mcycle #(.MC_DIV(MC_DIV)) u_mcyc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (sys_tick),
        .stb   (mc_stb)
    );

    always_comb begin
        st_d      = st_q;
        st_d.stop = stop_mode;
        // a source swap is applied only when neither candidate is ticking
        if (!hf_tick && !lf_tick)
            st_d.sel_sys = sys_slow ? SRC_SLOW : SRC_FAST;
        if (!lf_tick && !lo_stage[SPLIT-1])
            st_d.sel7 = (sys_slow | s7_from_lf) ? SRC_SLOW : SRC_FAST;
        st_d.sys_en = sys_tick & ~clr;
        st_d.mcyc   = mc_stb & ~clr;
        st_d.taps   = clr ? '0 : {hi_stage, lo_stage};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stop    <= 1'b0;
            st_q.sel_sys <= SRC_FAST;
            st_q.sel7    <= SRC_FAST;
            st_q.sys_en  <= 1'b0;
            st_q.mcyc    <= 1'b0;
            st_q.taps    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_en    = st_q.sys_en;
    assign mcyc_stb  = st_q.mcyc;
    assign tap_en    = st_q.taps;
    assign tbt_tick  = st_q.taps[TBT_STAGE-1];
    assign wdt_tick  = st_q.taps[WDT_STAGE-1];
    assign tmr_tick  = st_q.taps[TMR_STAGE-1];
    assign dvo_tick  = st_q.taps[DVO_STAGE-1];
    assign wup_tick  = st_q.taps[WUP_STAGE-1];
    assign div_state = {hi_cnt, lo_cnt};
endmodule

// File: rtl/tgen_checker.sv
module tgen_checker #(
    parameter int PRE_W    = 2,
    parameter int N_STAGES = 21,
    parameter int SPLIT    = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      hf_tick,
    input logic                      lf_tick,
    input logic                      stop_mode,
    input logic                      sys_en,
    input logic                      mcyc_stb,
    input logic [N_STAGES-1:0]       tap_en,
    input logic [N_STAGES+PRE_W-1:0] div_state
);
    a_r4_mcyc_with_sys: assert property (@(posedge clk) disable iff (!rst_n)
        mcyc_stb |-> sys_en);

    a_r4_mcyc_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mcyc_stb |=> !mcyc_stb);

    a_r2_sys_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en |-> $past(hf_tick || lf_tick));

    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> (div_state == '0 && tap_en == '0 && !sys_en && !mcyc_stb));

    a_r8_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_mode) |=> (div_state == '0 && tap_en == '0));

    for (genvar n = 1; n < SPLIT; n++) begin : g_lo
        a_r5_lo_nest: assert property (@(posedge clk) disable iff (!rst_n)
            tap_en[n] |-> tap_en[n-1]);
    end

    for (genvar n = SPLIT + 1; n < N_STAGES; n++) begin : g_hi
        a_r6_hi_nest: assert property (@(posedge clk) disable iff (!rst_n)
            tap_en[n] |-> tap_en[n-1]);
    end
endmodule

bind tgen_top tgen_checker #(
    .PRE_W    (PRE_W),
    .N_STAGES (N_STAGES),
    .SPLIT    (SPLIT)
) u_tgen_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hf_tick   (hf_tick),
    .lf_tick   (lf_tick),
    .stop_mode (stop_mode),
    .sys_en    (sys_en),
    .mcyc_stb  (mcyc_stb),
    .tap_en    (tap_en),
    .div_state (div_state)
);

// File: tb/tgen_top_bench.sv
`timescale 1ns/1ps
module tgen_top_bench;
    localparam int NST = 21;
    localparam int DW  = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hf_tick = 1'b0, lf_tick = 1'b0, stop_mode = 1'b0;
    logic sys_slow = 1'b0, s7_from_lf = 1'b0;
    logic sys_en, mcyc_stb, tbt_tick, wdt_tick, tmr_tick, dvo_tick, wup_tick;
    logic [NST-1:0] tap_en;
    logic [DW-1:0]  div_state;

    always #2 clk = ~clk;

    tgen_top u_tgen_top (
        .clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .lf_tick(lf_tick),
        .stop_mode(stop_mode), .sys_slow(sys_slow), .s7_from_lf(s7_from_lf),
        .sys_en(sys_en), .mcyc_stb(mcyc_stb), .tap_en(tap_en),
        .tbt_tick(tbt_tick), .wdt_tick(wdt_tick), .tmr_tick(tmr_tick),
        .dvo_tick(dvo_tick), .wup_tick(wup_tick), .div_state(div_state)
    );

    int vectors = 0, miscompares = 0;
    bit cmp_en = 0;
    bit finished = 0;
    string focus = "R5";

    // behavioural model state
    int m_lo = 0, m_hi = 0, m_mc = 0;
    bit m_sys_slow = 0, m_s7 = 0, m_stop = 0;
    bit e_sys = 0, e_mcyc = 0;
    bit e_tap[1:NST];
    longint e_div = 0;
    bit hi_hit = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_mc = 0;
            m_sys_slow = 0; m_s7 = 0; m_stop = 0;
            e_sys = 0; e_mcyc = 0; e_div = 0;
            for (int n = 1; n <= NST; n++) e_tap[n] = 0;
        end else begin
            bit clear, c6, src, st;
            clear = stop_mode || m_stop;
            c6  = hf_tick && ((m_lo + 1) % 256 == 0);
            src = m_s7 ? lf_tick : c6;
            st  = m_sys_slow ? lf_tick : hf_tick;
            for (int n = 1; n <= 6; n++)
                e_tap[n] = !clear && hf_tick && ((m_lo + 1) % (1 << (n + 2)) == 0);
            for (int n = 7; n <= NST; n++)
                e_tap[n] = !clear && src && ((m_hi + 1) % (1 << (n - 6)) == 0);
            e_sys  = !clear && st;
            e_mcyc = !clear && st && ((m_mc + 1) % 4 == 0);
            if (clear) begin
                m_lo = 0; m_hi = 0; m_mc = 0;
            end else begin
                if (hf_tick) m_lo = (m_lo + 1) % 256;
                if (src)     m_hi = (m_hi + 1) % 32768;
                if (st)      m_mc = (m_mc + 1) % 4;
            end
            if (!hf_tick && !lf_tick) m_sys_slow = sys_slow;
            if (!lf_tick && !c6)      m_s7 = sys_slow | s7_from_lf;
            m_stop = stop_mode;
            e_div = longint'(m_hi) * 256 + m_lo;
        end
    end

    function automatic bit exp_tap(int stage);
        return e_tap[stage];
    endfunction

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            bit bad;
            bad = 0;
            vectors++;
            if (sys_en !== e_sys) begin
                bad = 1;
                $display("FAIL R2 (%s) sys_en actual %0b expected %0b", focus, sys_en, e_sys);
            end
            if (mcyc_stb !== e_mcyc) begin
                bad = 1;
                $display("FAIL R4 (%s) mcyc_stb actual %0b expected %0b", focus, mcyc_stb, e_mcyc);
            end
            for (int n = 1; n <= NST; n++) begin
                if (tap_en[n-1] !== e_tap[n]) begin
                    bad = 1;
                    $display("FAIL %s (%s) stage %0d tap actual %0b expected %0b",
                             (n <= 6) ? "R5" : "R6", focus, n, tap_en[n-1], e_tap[n]);
                end
                if (n == NST && e_tap[n]) hi_hit = 1;
            end
            if ({tbt_tick, wdt_tick, tmr_tick, dvo_tick, wup_tick} !==
                {exp_tap(14), exp_tap(21), exp_tap(3), exp_tap(10), exp_tap(8)}) begin
                bad = 1;
                $display("FAIL R9 (%s) named taps actual %b expected %b", focus,
                         {tbt_tick, wdt_tick, tmr_tick, dvo_tick, wup_tick},
                         {exp_tap(14), exp_tap(21), exp_tap(3), exp_tap(10), exp_tap(8)});
            end
            if (longint'(div_state) != e_div) begin
                bad = 1;
                $display("FAIL R10 (%s) div_state actual %0d expected %0d", focus, div_state, e_div);
            end
            if (bad) miscompares++;
        end
    end

    int hf_per = 2, lf_per = 3, cyc = 0;

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            hf_tick = (hf_per != 0) && (cyc % hf_per == 0);
            lf_tick = (lf_per != 0) && (cyc % lf_per == 0);
        end
    endtask

    task automatic check_zero(string tag);
        vectors++;
        if (sys_en !== 1'b0 || mcyc_stb !== 1'b0 || tap_en !== '0 || div_state !== '0 ||
            {tbt_tick, wdt_tick, tmr_tick, dvo_tick, wup_tick} !== 5'b0) begin
            miscompares++;
            $display("FAIL %s cleared state actual div=%0d taps=%h sys=%0b expected all zero",
                     tag, div_state, tap_en, sys_en);
        end
    endtask

    task automatic do_reset();
        cmp_en = 0;
        rst_n = 0;
        run(4);
        check_zero("R1");
        rst_n = 1;
        @(posedge clk);
        cmp_en = 1;
    endtask

    initial begin
        do_reset();
        // R5 R10: fast ticks every cycle, then every other cycle
        focus = "R5"; hf_per = 1; lf_per = 3;
        run(1500);
        hf_per = 2;
        run(1500);
        // R6: slow tick drives stage 7 up to stage 21
        focus = "R6"; s7_from_lf = 1;
        run(99000);
        vectors++;
        if (!hi_hit) begin
            miscompares++;
            $display("FAIL R6 stage 21 pulse actual 0 expected 1");
        end
        // R8: STOP entry and exit clear the chain
        focus = "R8"; s7_from_lf = 0;
        run(300);
        stop_mode = 1;
        run(2);
        check_zero("R8");
        run(40);
        stop_mode = 0;
        run(1);
        @(posedge clk); @(negedge clk);
        check_zero("R8");
        run(2000);
        // R2 R4: slow system clock
        focus = "R2"; sys_slow = 1; lf_per = 5;
        run(3000);
        // R3 R7: select swaps colliding with ticks
        focus = "R3/R7"; lf_per = 3; hf_per = 2;
        for (int k = 0; k < 70; k++) begin
            sys_slow   = k[0];
            s7_from_lf = k[1] ^ k[3];
            run(37 + (k % 5));
        end
        focus = "R7"; sys_slow = 0; s7_from_lf = 0;
        run(1200);
        // R1: reset in the middle of activity
        do_reset();
        // R2: fast clock stopped, slow system clock only
        focus = "R2"; hf_per = 0; lf_per = 4; sys_slow = 1;
        run(600);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule